// File: doc/BRIEF.md
# Block Memory Copy and Search Engine

This block is a small bus master that walks a block of bytes in a 64K byte address space. It holds three 16-bit registers: a byte count, a source pointer and a destination pointer. A one-cycle start pulse loads all three, together with an 8-bit key and a mode. The mode has three independent bits: copy or search, ascending or descending, and single step or repeat.

A copy step reads the byte at the source pointer and writes it at the destination pointer. A search step reads the byte at the source pointer and compares it with the key. Each step decrements the count and moves the pointers. In repeat mode the engine keeps stepping until the count is exhausted. A repeated search also stops at the first match. Memory is reached through a single-port request/acknowledge interface.

After completion the final count, the final pointers and four status flags stay on the outputs until the next start:
- parity/overflow, which here means the count is nonzero;
- zero, which here means the key matched;
- half borrow;
- subtract.

Top module: `blk_mover`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and all four flags are 0, and cnt_o, src_o and dst_o are 0.
- R2: A start_i pulse while idle latches the count, the pointers, the key and the mode, and busy_o rises in the next cycle. A start_i pulse while busy_o is 1 is ignored and has no effect on the results of the running operation.
- R3: Each copy step performs exactly one read transaction at the source pointer, followed by one write transaction of that byte at the destination pointer, and decrements the count by one.
- R4: After each step the pointers move by one: both increment when desc_i=0, both decrement when desc_i=1. They wrap modulo 65536 at both ends of the space.
- R5: With rpt_i=0 exactly one byte is processed. With rpt_i=1 stepping continues until the count reaches zero. A starting count of 0 is decremented to 0xFFFF, not treated as empty.
- R6: After every step, flag_pv_o is 1 if the decremented count is nonzero and 0 if it is zero.
- R7: A copy step sets flag_h_o and flag_n_o to 0 and leaves flag_z_o unchanged.
- R8: A search step (search_i=1) sets flag_z_o to 1 when the byte equals key_i and to 0 otherwise. It sets flag_n_o to 1, and sets flag_h_o to 1 when key_i[3:0] is less than byte[3:0]. A search never issues a write and never changes dst_o.
- R9: A repeated search stops after the first matching byte, or when the count reaches zero, whichever comes first. The pointer and count then reflect the matching byte as already processed.
- R10: done_o is high for exactly one cycle after the last step. busy_o is 0 in that cycle, and the final values and flags are valid then.
- R11: Once mem_req_o is raised, it stays high with mem_addr_o and mem_we_o unchanged until mem_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| search_i | input | 1 | 1 = search, 0 = copy |
| desc_i | input | 1 | 1 = decrement pointers, 0 = increment |
| rpt_i | input | 1 | 1 = repeat until done, 0 = single byte |
| cnt_i | input | 16 | Initial byte count |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| key_i | input | 8 | Search key |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transaction acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_o | output | 16 | Current count |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| flag_pv_o | output | 1 | Count nonzero after last step |
| flag_z_o | output | 1 | Key matched on last search step |
| flag_h_o | output | 1 | Low-nibble borrow on last search step |
| flag_n_o | output | 1 | Last step was a search |

## Verification
The bench sweeps all eight mode combinations over short counts and compares every register, every flag and the whole 64K memory image against an arithmetic model. Some sweeps place pointers next to 0x0000 and 0xFFFF, so a design that saturated or failed to wrap would leave the wrong pointer values and corrupt bytes at the far end.

Several corner cases are aimed at directly:
- A single step from count 0 must give 0xFFFF with P/V set; an engine that treated zero as empty would do nothing.
- A repeated search from count 0 with a match a few bytes in must stop at the match, exposing engines that run past a hit or that ignore the wrap.
- A copy that follows a matching search must keep Z set.
- A stray start in the middle of a run must not disturb it.

Random acknowledge stalls show up any request that drops or moves its address before the acknowledge.

// File: rtl/blk_pkg.sv
package blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blk_state_e;

  typedef struct packed {
    logic search;
    logic desc;
    logic rpt;
  } blk_op_t;
endpackage

// File: rtl/blk_seq.sv
module blk_seq
  import blk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  blk_op_t    op_i,
  input  logic       mem_ack_i,
  input  logic       match_i,
  input  logic       cnt_last_i,
  output blk_state_e state_o,
  output blk_op_t    op_o,
  output logic       load_o,
  output logic       step_o,
  output logic       done_o
);
  blk_state_e state_q, state_d;
  blk_op_t    op_q;
  logic       done_q, fin;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack_i) begin
          if (op_q.search) begin
            step_o = 1'b1;
            // stop on hit, on exhausted count, or after one byte
            if (op_q.rpt && !match_i && !cnt_last_i) state_d = ST_READ;
            else begin
              state_d = ST_IDLE;
              fin     = 1'b1;
            end
          end else begin
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack_i) begin
          step_o = 1'b1;
          if (op_q.rpt && !cnt_last_i) state_d = ST_READ;
          else begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (load_o) op_q <= op_i;
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign done_o  = done_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == ST_IDLE);
endmodule

// File: rtl/blk_regs.sv
module blk_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_ld_i,
  input  logic [AW-1:0] src_ld_i,
  input  logic [AW-1:0] dst_ld_i,
  input  logic          step_i,
  input  logic          desc_i,
  input  logic          step_dst_i,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_last_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  localparam int            NPTR  = 2;
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0] ld_val [NPTR];
  logic [AW-1:0] ptr_q  [NPTR];
  logic [CW-1:0] cnt_q, cnt_dec;

  assign ld_val[0] = src_ld_i;
  assign ld_val[1] = dst_ld_i;

  // index 0 is the source and moves on every step; index 1 only on copies
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam bit ALWAYS_MOVES = (i == 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[i] <= '0;
      else if (load_i) ptr_q[i] <= ld_val[i];
      else if (step_i && (ALWAYS_MOVES || step_dst_i))
        ptr_q[i] <= desc_i ? ptr_q[i] - ONE_A : ptr_q[i] + ONE_A;
    end
  end

  assign cnt_dec = cnt_q - ONE_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_ld_i;
    else if (step_i) cnt_q <= cnt_dec;
  end

  assign cnt_o      = cnt_q;
  assign cnt_last_o = (cnt_dec == '0);
  assign src_o      = ptr_q[0];
  assign dst_o      = ptr_q[1];

  p_cnt_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q + ONE_C) == $past(cnt_q));
endmodule

// File: rtl/blk_flags.sv
module blk_flags #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          search_i,
  input  logic          cnt_last_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] key_i,
  output logic          match_o,
  output logic          pv_o,
  output logic          z_o,
  output logic          h_o,
  output logic          n_o
);
  localparam int NIB = DW / 2;

  logic match, borrow;
  logic pv_q, z_q, h_q, n_q;

  assign match  = (rdata_i == key_i);
  assign borrow = (key_i[NIB-1:0] < rdata_i[NIB-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      z_q  <= 1'b0;
      h_q  <= 1'b0;
      n_q  <= 1'b0;
    end else if (step_i) begin
      pv_q <= !cnt_last_i;
      if (search_i) begin
        z_q <= match;
        h_q <= borrow;
        n_q <= 1'b1;
      end else begin
        h_q <= 1'b0;
        n_q <= 1'b0;
      end
    end
  end

  assign match_o = match;
  assign pv_o    = pv_q;
  assign z_o     = z_q;
  assign h_o     = h_q;
  assign n_o     = n_q;

  p_copy_keeps_z_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !search_i) |=> ($stable(z_q) && !h_q && !n_q));
endmodule

// File: rtl/blk_mover.sv
module blk_mover
  import blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          search_i,
  input  logic          desc_i,
  input  logic          rpt_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] key_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          flag_pv_o,
  output logic          flag_z_o,
  output logic          flag_h_o,
  output logic          flag_n_o
);
  blk_state_e    state;
  blk_op_t       op_in, op_q;
  logic          load, step, match, cnt_last;
  logic [DW-1:0] key_q, data_q;

  assign op_in = '{search: search_i, desc: desc_i, rpt: rpt_i};

  blk_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_in),
    .mem_ack_i  (mem_ack_i),
    .match_i    (match),
    .cnt_last_i (cnt_last),
    .state_o    (state),
    .op_o       (op_q),
    .load_o     (load),
    .step_o     (step),
    .done_o     (done_o)
  );

  blk_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cnt_ld_i   (cnt_i),
    .src_ld_i   (src_i),
    .dst_ld_i   (dst_i),
    .step_i     (step),
    .desc_i     (op_q.desc),
    .step_dst_i (!op_q.search),
    .cnt_o      (cnt_o),
    .cnt_last_o (cnt_last),
    .src_o      (src_o),
    .dst_o      (dst_o)
  );

  blk_flags #(.DW(DW)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .search_i   (op_q.search),
    .cnt_last_i (cnt_last),
    .rdata_i    (mem_rdata_i),
    .key_i      (key_q),
    .match_o    (match),
    .pv_o       (flag_pv_o),
    .z_o        (flag_z_o),
    .h_o        (flag_h_o),
    .n_o        (flag_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      data_q <= '0;
    end else begin
      if (load) key_q <= key_i;
      if (state == ST_READ && mem_ack_i) data_q <= mem_rdata_i;
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_o : src_o;
  assign mem_wdata_o = data_q;

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  p_search_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q.search) |-> !mem_we_o);
  p_search_dst_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q.search) |=> $stable(dst_o));
  p_pv_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flag_pv_o == (cnt_o != '0)));
  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(key_q));
endmodule

// File: tb/tb_blk_mover.sv
`timescale 1ns/1ps
module tb_blk_mover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 0, search = 0, desc = 0, rpt = 0;
  logic [15:0] cnt_in = 0, src_in = 0, dst_in = 0;
  logic [7:0]  key_in = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] cnt_o, src_o, dst_o;
  logic        f_pv, f_z, f_h, f_n;

  blk_mover dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .search_i(search), .desc_i(desc),
    .rpt_i(rpt), .cnt_i(cnt_in), .src_i(src_in), .dst_i(dst_in), .key_i(key_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .busy_o(busy), .done_o(done), .cnt_o(cnt_o), .src_o(src_o), .dst_o(dst_o),
    .flag_pv_o(f_pv), .flag_z_o(f_z), .flag_h_o(f_h), .flag_n_o(f_n)
  );

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // memory model with random stalls
  logic [7:0]  mem [65536];
  logic [7:0]  em  [65536];
  int          n_rd = 0, n_wr = 0;
  logic        tb_we = 0;
  logic [15:0] tb_wa = 0;
  logic [7:0]  tb_wd = 0;
  logic        prev_wait = 0, hold_bad = 0, prev_we = 0;
  logic [15:0] prev_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
      prev_wait <= 1'b0;
      for (int i = 0; i < 65536; i++) mem[i] <= init_byte(i);
    end else begin
      if (tb_we) mem[tb_wa] <= tb_wd;
      if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) hold_bad <= 1'b1;
      prev_wait <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
      if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          n_rd <= n_rd + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  int checks = 0, errors = 0;
  logic [15:0] e_c, e_s, e_d;
  logic e_pv = 0, e_z = 0, e_h = 0, e_n = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke_byte(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a; tb_wd = v;
    @(negedge clk);
    tb_we = 1'b0;
    em[a] = v;
  endtask

  task automatic model(input bit srch, input bit dsc, input bit rp, input logic [15:0] c,
                       input logic [15:0] s, input logic [15:0] d, input logic [7:0] k,
                       output int nr, output int nw);
    bit go = 1'b1;
    logic [7:0] b;
    nr = 0; nw = 0;
    while (go) begin
      b = em[s];
      nr++;
      if (!srch) begin
        em[d] = b;
        nw++;
        d = dsc ? d - 16'd1 : d + 16'd1;
      end
      s = dsc ? s - 16'd1 : s + 16'd1;
      c = c - 16'd1;
      e_pv = (c != 16'd0);
      if (srch) begin
        e_z = (b == k);
        e_h = (k[3:0] < b[3:0]);
        e_n = 1'b1;
      end else begin
        e_h = 1'b0;
        e_n = 1'b0;
      end
      go = rp && (c != 16'd0) && !(srch && b == k);
    end
    e_c = c; e_s = s; e_d = d;
  endtask

  task automatic run_op(input bit srch, input bit dsc, input bit rp, input logic [15:0] c,
                        input logic [15:0] s, input logic [15:0] d, input logic [7:0] k,
                        input bit stray);
    int nr, nw, r0, w0, cyc, mism;
    string rq;
    model(srch, dsc, rp, c, s, d, k, nr, nw);
    @(negedge clk);
    r0 = n_rd; w0 = n_wr;
    start = 1'b1; search = srch; desc = dsc; rpt = rp;
    cnt_in = c; src_in = s; dst_in = d; key_in = k;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (stray && cyc == 3) begin
        start = 1'b1; search = ~srch; desc = ~dsc; rpt = 1'b0;
        cnt_in = 16'h0077; src_in = 16'h4444; dst_in = 16'h5555; key_in = ~k;
      end
      if (stray && cyc == 4) start = 1'b0;
    end
    if (!done) chk("R10", "op timeout", 0, 1);
    rq = stray ? "R2" : "R5";
    chk(rq, "count", cnt_o, e_c);
    chk(srch ? "R9" : "R4", "src", src_o, e_s);
    chk(srch ? "R8" : "R4", "dst", dst_o, e_d);
    chk("R6", "pv", f_pv, e_pv);
    chk(srch ? "R8" : "R7", "z", f_z, e_z);
    chk(srch ? "R8" : "R7", "h", f_h, e_h);
    chk(srch ? "R8" : "R7", "n", f_n, e_n);
    chk("R10", "busy at done", busy, 0);
    chk("R3", "reads", n_rd - r0, nr);
    chk(srch ? "R8" : "R3", "writes", n_wr - w0, nw);
    mism = 0;
    for (int i = 0; i < 65536; i++) if (mem[i] !== em[i]) mism++;
    chk("R3", "memory mismatches", mism, 0);
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
  endtask

  task automatic main_seq;
    logic [15:0] b;
    for (int i = 0; i < 65536; i++) em[i] = init_byte(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "req", mem_req, 0);
    chk("R1", "regs", {cnt_o, src_o}, 0);
    chk("R1", "dst", dst_o, 0);
    chk("R1", "flags", {f_pv, f_z, f_h, f_n}, 0);

    // sweep of all modes and short counts, some near the address ends
    for (int m = 0; m < 8; m++) begin
      for (int c = 1; c <= 5; c++) begin
        b = (c % 2 == 1) ? 16'hFFFD : 16'(16'h1000 + m * 64 + c * 8);
        run_op(m[2], m[1], m[0], 16'(c), b, 16'(b + 16'h0800),
               (c > 2) ? em[16'(m[1] ? b - 16'd2 : b + 16'd2)] : 8'hEE, 1'b0);
      end
    end

    // R5 single step from count 0 wraps the count
    run_op(1'b0, 1'b0, 1'b0, 16'h0000, 16'h2000, 16'h3000, 8'h00, 1'b0);
    chk("R5", "single step wrap count", cnt_o, 16'hFFFF);
    chk("R6", "pv after wrap", f_pv, 1);

    // R9 repeated search from count 0 stops at match two bytes in
    poke_byte(16'h6000, 8'h3C);
    poke_byte(16'h6001, 8'h3D);
    poke_byte(16'h6002, 8'h3E);
    run_op(1'b1, 1'b0, 1'b1, 16'h0000, 16'h6000, 16'h7000, 8'h3E, 1'b0);
    chk("R9", "stop count", cnt_o, 16'hFFFD);
    chk("R9", "stop src", src_o, 16'h6003);
    chk("R8", "match z", f_z, 1);

    // R7 copy keeps z from the previous search
    run_op(1'b0, 1'b1, 1'b1, 16'd3, 16'h6100, 16'h6200, 8'h00, 1'b0);
    chk("R7", "z retained", f_z, 1);

    // R8 half borrow both ways
    poke_byte(16'h6300, 8'h01);
    run_op(1'b1, 1'b0, 1'b0, 16'd1, 16'h6300, 16'h0000, 8'h10, 1'b0);
    chk("R8", "h borrow set", f_h, 1);
    chk("R8", "z miss", f_z, 0);
    run_op(1'b1, 1'b0, 1'b0, 16'd1, 16'h6300, 16'h0000, 8'h1F, 1'b0);
    chk("R8", "h borrow clear", f_h, 0);

    // R2 stray start while busy
    run_op(1'b0, 1'b0, 1'b1, 16'd6, 16'h6400, 16'h6500, 8'h00, 1'b1);

    // R11 request held while waiting
    chk("R11", "request held until ack", hold_bad, 0);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=1 expected=0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule